// File: doc/BRIEF.md
# Audio Master Clock Ratio Divider

This block runs on the audio port base clock, which is 512 or 384 times the sample rate. From that clock it derives two outputs. The first is a master clock, given as one-cycle enable pulses. A 3-bit ratio code sets a power-of-two divide of the base clock for this pulse train. The same code means a different oversampling ratio with each base, so codes 0 to 4 give 512, 256, 128, 64 and 32 times fs on the 512 base, and codes 0 to 3 give 384, 192, 96 and 48 times fs on the 384 base. The second output is a serial bit clock at 32 or 48 times the sample rate. The 48x setting serves 20-bit and 24-bit words.

A phase accumulator produces the bit clock. It advances by twice the slot count on every base cycle and toggles the output each time it wraps at the frame length. The bit clock period therefore averages out exactly, even when the frame length is not a whole multiple of it, as with 512 cycles and 48 slots. Both outputs are held low while the run input is low. Sample rates from 8 kHz to 192 kHz are covered because every rate here is a ratio of fs.

Top module: `audio_clk_ratio_div`

## Requirements
- R1: With `base_is_384`=0, ratio codes 0, 1, 2, 3 and 4 make `mclk_en` a one-cycle pulse every 1, 2, 4, 8 and 16 base cycles. These are ratios of 512, 256, 128, 64 and 32 times fs. Code 0 holds `mclk_en` high on every cycle.
- R2: With `base_is_384`=1, ratio codes 0, 1, 2 and 3 give a pulse every 1, 2, 4 and 8 base cycles. These are ratios of 384, 192, 96 and 48 times fs.
- R3: Codes that are out of range use the largest legal divide. On the 512 base, codes 5 to 7 give period 16. On the 384 base, codes 4 to 7 give period 8.
- R4: While `run_en` is sampled low, `mclk_en` and `bclk` are low from the following cycle on. On the first edge that samples `run_en` high, `mclk_en` goes high in the cycle that follows that edge.
- R5: When the effective divide changes and the change is sampled at edge E, the counter restarts. `mclk_en` is low after E and high after E+1, and the new period follows from there. No shortened pulse spacing appears.
- R6: With `bclk_48x`=0, any window of F consecutive running cycles holds exactly 32 rising edges of `bclk`. F is 512, or 384 when `base_is_384`=1.
- R7: With `bclk_48x`=1, any such window of F cycles holds exactly 48 rising edges of `bclk`.
- R8: While running with a steady configuration, every `bclk` level lasts floor(F/2B) or ceil(F/2B) base cycles, where B is 32 or 48.
- R9: A change of `base_is_384` or `bclk_48x` sampled at edge E sets `bclk` low after E. The first rising edge then comes after edge E+ceil(F/2B), and exactly B rising edges fall in the F cycles that follow E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port base clock (512 or 384 times fs) |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Enables both clock outputs |
| base_is_384 | input | 1 | 0: base is 512 fs, 1: base is 384 fs |
| ratio_code | input | CODE_W | Power-of-two master clock divide code |
| bclk_48x | input | 1 | 1: bit clock 48 fs, 0: bit clock 32 fs |
| mclk_en | output | 1 | Master clock enable pulse, one base cycle wide |
| bclk | output | 1 | Serial bit clock level |

## Verification
The bench sweeps all eight codes on both bases and measures pulse spacing. A design that ignored the base when clamping would emit 24x pulses for code 4 on the 384 base, and that shows up as a wrong spacing. It changes the divide while running and checks the exact restart cycles, which catches a counter that keeps its old phase and emits a runt spacing. The 512-cycle frame with 48 slots is the uneven case: a divider based on integer truncation would give 51 or 42 edges per frame instead of 48, or levels outside the 5-to-6 cycle band. The run-gating and configuration-change checks catch outputs that leak while the block is idle and a phase accumulator that is not cleared on restart.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

  // Effective divide exponent: the 384 base loses one step of range
  function automatic int unsigned clamp_shift(input logic base384,
                                              input int unsigned code,
                                              input int unsigned max_full);
    int unsigned lim;
    lim = base384 ? (max_full - 1) : max_full;
    return (code > lim) ? lim : code;
  endfunction

  // Base cycles in one sample frame
  function automatic int unsigned frame_len(input logic base384,
                                            input int unsigned full_len,
                                            input int unsigned alt_len);
    return base384 ? alt_len : full_len;
  endfunction

  // Accumulator increment: two toggles per bit clock period
  function automatic int unsigned bclk_step(input logic wide,
                                            input int unsigned narrow_slots,
                                            input int unsigned wide_slots);
    return 2 * (wide ? wide_slots : narrow_slots);
  endfunction

  function automatic int unsigned ceil_div(input int unsigned num,
                                           input int unsigned den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/mclk_ratio_div.sv
module mclk_ratio_div
  import audclk_pkg::*;
#(
  parameter int unsigned CODE_W    = 3,
  parameter int unsigned MAX_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              base384,
  input  logic [CODE_W-1:0] ratio_code,
  output logic              mclk_en
);

  localparam int unsigned CNT_W   = (MAX_SHIFT < 1) ? 1 : MAX_SHIFT;
  localparam int unsigned SHIFT_W = $clog2(MAX_SHIFT + 1);

  logic [SHIFT_W-1:0] eff_shift;
  logic [SHIFT_W-1:0] shift_q;
  logic               shift_chg;
  logic [CNT_W:0]     span;
  logic [CNT_W-1:0]   cnt_limit;
  logic [CNT_W-1:0]   cnt;
  logic               cnt_wrap;

  assign eff_shift = SHIFT_W'(clamp_shift(base384, 32'(ratio_code), MAX_SHIFT));
  assign span      = (CNT_W+1)'(1) << shift_q;
  assign cnt_limit = CNT_W'(span - 1'b1);
  assign shift_chg = (eff_shift != shift_q);
  assign cnt_wrap  = (cnt == cnt_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt     <= '0;
      mclk_en <= 1'b0;
    end else begin
      shift_q <= eff_shift;
      if (!run || shift_chg) begin
        cnt     <= '0;
        mclk_en <= 1'b0;
      end else begin
        mclk_en <= (cnt == '0);
        cnt     <= cnt_wrap ? '0 : cnt + 1'b1;
      end
    end
  end

  // Cycles since the last pulse, kept for the spacing check
  logic [CNT_W:0] gap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              gap <= '0;
    else if (!run || shift_chg || mclk_en)   gap <= '0;
    else                                     gap <= gap + 1'b1;
  end

  assert_pulse_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !mclk_en) |-> (gap <= (CNT_W+1)'(cnt_limit)));

  assert_clamp_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(eff_shift) <= (base384 ? (MAX_SHIFT - 1) : MAX_SHIFT));

  assert_idle_mclk_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mclk_en);

  assert_restart_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_chg |=> !mclk_en);

endmodule

// File: rtl/bclk_phase_gen.sv
module bclk_phase_gen
  import audclk_pkg::*;
#(
  parameter int unsigned FRAME_FULL   = 512,
  parameter int unsigned FRAME_ALT    = 384,
  parameter int unsigned SLOTS_NARROW = 32,
  parameter int unsigned SLOTS_WIDE   = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic base384,
  input  logic wide_en,
  output logic bclk
);

  localparam int unsigned ACC_W = $clog2(FRAME_FULL + 2 * SLOTS_WIDE + 1);

  logic [ACC_W-1:0] frame;
  logic [ACC_W-1:0] step;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] acc_sum;
  logic             wrap;
  logic [1:0]       cfg_q;
  logic             cfg_chg;

  assign frame   = ACC_W'(frame_len(base384, FRAME_FULL, FRAME_ALT));
  assign step    = ACC_W'(bclk_step(wide_en, SLOTS_NARROW, SLOTS_WIDE));
  assign acc_sum = acc + step;
  assign wrap    = (acc_sum >= frame);
  assign cfg_chg = (cfg_q != {base384, wide_en});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= 2'b00;
      acc   <= '0;
      bclk  <= 1'b0;
    end else begin
      cfg_q <= {base384, wide_en};
      if (!run || cfg_chg) begin
        acc  <= '0;
        bclk <= 1'b0;
      end else begin
        acc <= wrap ? (acc_sum - frame) : acc_sum;
        if (wrap) bclk <= ~bclk;
      end
    end
  end

  // Level hold length, kept for the level-width check
  logic [ACC_W-1:0] hold;
  logic             bclk_prev;
  logic [ACC_W-1:0] hold_lim;

  assign hold_lim = ACC_W'(ceil_div(32'(frame), 32'(step)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold      <= '0;
      bclk_prev <= 1'b0;
    end else begin
      bclk_prev <= bclk;
      if (!run || cfg_chg || (bclk != bclk_prev)) hold <= '0;
      else                                        hold <= hold + 1'b1;
    end
  end

  assert_level_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cfg_chg && (bclk == bclk_prev)) |-> (hold <= hold_lim));

  assert_idle_bclk_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !bclk);

  assert_cfg_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> !bclk);

endmodule

// File: rtl/audio_clk_ratio_div.sv
module audio_clk_ratio_div #(
  parameter int unsigned CODE_W       = 3,
  parameter int unsigned MAX_SHIFT    = 4,
  parameter int unsigned FRAME_FULL   = 512,
  parameter int unsigned FRAME_ALT    = 384,
  parameter int unsigned SLOTS_NARROW = 32,
  parameter int unsigned SLOTS_WIDE   = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              base_is_384,
  input  logic [CODE_W-1:0] ratio_code,
  input  logic              bclk_48x,
  output logic              mclk_en,
  output logic              bclk
);

  mclk_ratio_div #(
    .CODE_W   (CODE_W),
    .MAX_SHIFT(MAX_SHIFT)
  ) u_mclk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_en),
    .base384   (base_is_384),
    .ratio_code(ratio_code),
    .mclk_en   (mclk_en)
  );

  bclk_phase_gen #(
    .FRAME_FULL  (FRAME_FULL),
    .FRAME_ALT   (FRAME_ALT),
    .SLOTS_NARROW(SLOTS_NARROW),
    .SLOTS_WIDE  (SLOTS_WIDE)
  ) u_bclk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run_en),
    .base384(base_is_384),
    .wide_en(bclk_48x),
    .bclk   (bclk)
  );

endmodule

// File: tb/audio_clk_ratio_div_tb.sv
module audio_clk_ratio_div_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_en = 1'b0;
  logic       base_is_384 = 1'b0;
  logic [2:0] ratio_code = 3'd0;
  logic       bclk_48x = 1'b0;
  logic       mclk_en;
  logic       bclk;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_clk_ratio_div dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .base_is_384(base_is_384),
    .ratio_code (ratio_code),
    .bclk_48x   (bclk_48x),
    .mclk_en    (mclk_en),
    .bclk       (bclk)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected spacing: halve the ratio per code step, never below the floor ratio
  function automatic int exp_period(bit b384, int code);
    int full_r;
    int floor_r;
    int ratio;
    full_r  = b384 ? 384 : 512;
    floor_r = b384 ? 48 : 32;
    ratio   = full_r;
    for (int i = 0; i < code; i++)
      if (ratio / 2 >= floor_r) ratio = ratio / 2;
    return full_r / ratio;
  endfunction

  task automatic measure_mclk(input int n, output int pulses, output int min_gap,
                              output int max_gap);
    int last;
    last = -1; pulses = 0; min_gap = 1000000; max_gap = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mclk_en) begin
        if (last >= 0) begin
          if (i - last < min_gap) min_gap = i - last;
          if (i - last > max_gap) max_gap = i - last;
        end
        last = i;
        pulses++;
      end
    end
  endtask

  task automatic t_reset();
    chk(mclk_en == 1'b0, "R4 reset mclk_en", int'(mclk_en), 0);
    chk(bclk == 1'b0, "R4 reset bclk", int'(bclk), 0);
  endtask

  task automatic t_ratio(input bit b384, input int code);
    int p, mn, mx, e;
    string tag;
    @(negedge clk);
    base_is_384 = b384;
    ratio_code  = 3'(code);
    run_en      = 1'b1;
    repeat (40) @(negedge clk);
    measure_mclk(128, p, mn, mx);
    e = exp_period(b384, code);
    if (b384) tag = (code > 3) ? "R3 clamp 384" : "R2 ratio 384";
    else      tag = (code > 4) ? "R3 clamp 512" : "R1 ratio 512";
    chk(mn == e, {tag, " min spacing"}, mn, e);
    chk(mx == e, {tag, " max spacing"}, mx, e);
    chk(p == 128 / e, {tag, " pulse count"}, p, 128 / e);
  endtask

  task automatic t_run_gate();
    bit quiet;
    @(negedge clk);
    base_is_384 = 1'b0; ratio_code = 3'd2; bclk_48x = 1'b0; run_en = 1'b1;
    repeat (30) @(negedge clk);
    run_en = 1'b0;
    quiet = 1'b1;
    repeat (12) begin
      @(negedge clk);
      if (mclk_en || bclk) quiet = 1'b0;
    end
    chk(quiet, "R4 outputs low while stopped", int'(quiet), 1);
    run_en = 1'b1;
    @(negedge clk);
    chk(mclk_en == 1'b1, "R4 first pulse after start", int'(mclk_en), 1);
  endtask

  task automatic t_restart();
    int first_gap;
    @(negedge clk);
    base_is_384 = 1'b0; ratio_code = 3'd1; run_en = 1'b1;
    repeat (20) @(negedge clk);
    ratio_code = 3'd3;
    @(negedge clk);
    chk(mclk_en == 1'b0, "R5 low after change edge", int'(mclk_en), 0);
    @(negedge clk);
    chk(mclk_en == 1'b1, "R5 pulse one edge later", int'(mclk_en), 1);
    first_gap = 0;
    for (int i = 1; i <= 16; i++) begin
      @(negedge clk);
      if (mclk_en && first_gap == 0) first_gap = i;
    end
    chk(first_gap == 8, "R5 new spacing after restart", first_gap, 8);
  endtask

  task automatic t_bclk(input bit b384, input bit b48);
    int f, b, lo, hi, rises, mnl, mxl, len;
    bit prev, first;
    string tag;
    f  = b384 ? 384 : 512;
    b  = b48 ? 48 : 32;
    lo = f / (2 * b);
    hi = (f + 2 * b - 1) / (2 * b);
    tag = b48 ? "R7 48 slots" : "R6 32 slots";
    @(negedge clk);
    run_en = 1'b0; base_is_384 = b384; bclk_48x = b48;
    @(negedge clk);
    run_en = 1'b1;
    repeat (f + 7) @(negedge clk);
    prev = bclk; first = 1'b1; rises = 0; mnl = 1000000; mxl = 0; len = 0;
    for (int i = 0; i < f; i++) begin
      @(negedge clk);
      if (bclk != prev) begin
        if (bclk) rises++;
        if (!first) begin
          if (len < mnl) mnl = len;
          if (len > mxl) mxl = len;
        end
        first = 1'b0;
        len = 1;
        prev = bclk;
      end else begin
        len++;
      end
    end
    chk(rises == b, {tag, " rises per frame"}, rises, b);
    chk(mnl >= lo, "R8 shortest level", mnl, lo);
    chk(mxl <= hi, "R8 longest level", mxl, hi);
  endtask

  task automatic t_cfg_change();
    int rises, first_hi;
    bit prev;
    @(negedge clk);
    run_en = 1'b1; base_is_384 = 1'b0; bclk_48x = 1'b0;
    repeat (600) @(negedge clk);
    bclk_48x = 1'b1;
    @(negedge clk);
    chk(bclk == 1'b0, "R9 low after config edge", int'(bclk), 0);
    prev = 1'b0; rises = 0; first_hi = 0;
    for (int j = 1; j <= 512; j++) begin
      @(negedge clk);
      if (bclk && !prev) rises++;
      if (bclk && first_hi == 0) first_hi = j;
      prev = bclk;
    end
    chk(first_hi == 6, "R9 first rise after restart", first_hi, 6);
    chk(rises == 48, "R9 rises in frame after restart", rises, 48);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    for (int c = 0; c < 8; c++) t_ratio(1'b0, c);
    for (int c = 0; c < 8; c++) t_ratio(1'b1, c);
    t_run_gate();
    t_restart();
    t_bclk(1'b0, 1'b0);
    t_bclk(1'b0, 1'b1);
    t_bclk(1'b1, 1'b0);
    t_bclk(1'b1, 1'b1);
    t_cfg_change();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog all requirements actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule